// File: doc/BRIEF.md
# Bank-Side SIMD Program Sequencer

This block is a small processing unit placed next to one DRAM bank. It holds a short stored program and steps through it once per column command that the memory controller sends to the bank, so the command stream itself paces execution. Each accepted command carries the 256-bit column data. The current instruction then loads that data into a wide register, folds it into an accumulator through a 16-lane multiply-accumulate, or emits an accumulator as write data for the bank. A counted backward jump replays a stretch of program. The commands that follow feed it again, so an eight-command burst runs eight loop iterations.

Software loads three register files through a programming port while the unit is idle: the instruction store (32 × 32 bits), the vector registers (16 × 256 bits, split into group A at indices 0–7 and group B at 8–15) and the scalar registers (16 × 16 bits). A start pulse launches the program from address 0. The unit reports busy while running and done after the exit instruction.

Commands enter over a valid/ready stream. `cmd_ready` is high only while the unit is running, the current instruction consumes a command, and no result is waiting at the output. Results leave over a second valid/ready stream. A result stays valid with unchanged data until `out_ready` is sampled high. While it waits, no further command is accepted.

Top module: `pim_bank_seq`

## Requirements
- R1: After reset, busy, done, cmd_ready and out_valid are all 0, and cmd_ready is never 1 while busy is 0.
- R2: A start pulse while idle raises busy on the next cycle, clears done, and begins execution at instruction address 0.
- R3: A programming write (`prog_sel` 0 = instruction store, 1 = vector register, 2 = scalar register, at `prog_addr`) takes effect only while busy is 0; while busy it is ignored.
- R4: The opcode is instruction bits [31:28]: 1 MOV, 2 MAC, 3 FILL, 4 JUMP, 15 EXIT, any other value a no-op. Each accepted command retires exactly one MOV, MAC, FILL or no-op.
- R5: MOV writes the command data into vector register bits [27:24].
- R6: MAC adds, lane by lane, the command data times register A (bits [23:21]) into register B (8 + bits [20:18]). Lane k is bits [16k+15:16k], 16-bit two's complement with wrap-around.
- R7: With MAC bit [17] set, both the A index and the B index come from `cmd_col[2:0]` instead of the instruction fields.
- R8: With MAC bit [16] set, the multiplier is scalar register bits [15:12], broadcast to all 16 lanes, in place of register A.
- R9: FILL on a write command (`cmd_wr` = 1) emits register 8 + bits [20:18] on the output stream. FILL on a read command retires with no output.
- R10: JUMP moves back by bits [16:12] and, on first arrival, repeats bits [11:0] times before falling through. A count of 0 falls through at once. JUMP consumes no command.
- R11: EXIT consumes no command. It drops busy and raises done in the same cycle, and done stays high until the next start.
- R12: A valid output holds its data stable until `out_ready` is 1, and cmd_ready stays 0 while out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch program from address 0 (idle only) |
| busy | output | 1 | Program running |
| done | output | 1 | Program reached EXIT |
| prog_we | input | 1 | Programming write strobe |
| prog_sel | input | 2 | Target file: 0 instructions, 1 vector, 2 scalar |
| prog_addr | input | 5 | Entry index in the target file |
| prog_wdata | input | 256 | Write data (low bits used for narrow files) |
| cmd_valid | input | 1 | Column command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_wr | input | 1 | 1 = column write, 0 = column read |
| cmd_col | input | 3 | Low column address bits |
| cmd_data | input | 256 | Bank column data |
| out_valid | output | 1 | Result available for the bank |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Result write data |

## Verification
The assertions assume that the command source follows the handshake, that out_ready is a plain level, and that start arrives as a single-cycle pulse. Under those assumptions, the output stream is checked to hold its data under back-pressure, busy and done are checked to be exclusive, and done is checked to rise only as busy falls. The stimulus changes inputs only between clock edges. It keeps each command valid until cmd_ready accepts it and releases out_ready only after it has checked the held value. It loads programs only while the unit is idle, except in the single test that checks that writes made during a run are ignored.

// File: rtl/pim_seq_pkg.sv
package pim_seq_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_MOV  = 4'h1,
    OP_MAC  = 4'h2,
    OP_FILL = 4'h3,
    OP_JUMP = 4'h4,
    OP_EXIT = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    TGT_CRF = 2'd0,
    TGT_GRF = 2'd1,
    TGT_SRF = 2'd2
  } prog_tgt_e;

  // instruction field positions
  localparam int OPC_HI   = 31;
  localparam int MOVD_LO  = 24;
  localparam int AIDX_LO  = 21;
  localparam int BIDX_LO  = 18;
  localparam int AAM_BIT  = 17;
  localparam int SCAL_BIT = 16;
  localparam int SIDX_LO  = 12;
  localparam int JDST_LO  = 12;
  localparam int JDST_W   = 5;
  localparam int JCNT_W   = 12;
endpackage

// File: rtl/pim_crf.sv
module pim_crf #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pim_grf.sv
module pim_grf #(
  parameter int DEPTH = 16,
  parameter int W     = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/pim_simd_mac.sv
module pim_simd_mac #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  localparam int VW    = LANES * LANE_W
) (
  input  logic [VW-1:0] acc,
  input  logic [VW-1:0] mul_x,
  input  logic [VW-1:0] mul_y,
  output logic [VW-1:0] sum
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sum[g*LANE_W +: LANE_W] =
      acc[g*LANE_W +: LANE_W] + mul_x[g*LANE_W +: LANE_W] * mul_y[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/pim_bank_seq.sv
module pim_bank_seq
  import pim_seq_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int LANE_W    = 16,
  parameter int CRF_DEPTH = 32,
  parameter int INS_W     = 32,
  parameter int GRF_DEPTH = 16,
  parameter int SRF_DEPTH = 16,
  parameter int COL_W     = 3,
  localparam int VW       = LANES * LANE_W,
  localparam int CRF_AW   = $clog2(CRF_DEPTH),
  localparam int GRF_AW   = $clog2(GRF_DEPTH),
  localparam int GRP_AW   = GRF_AW - 1,
  localparam int SRF_AW   = $clog2(SRF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              prog_we,
  input  logic [1:0]        prog_sel,
  input  logic [CRF_AW-1:0] prog_addr,
  input  logic [VW-1:0]     prog_wdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_wr,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [VW-1:0]     cmd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VW-1:0]     out_data
);
  logic [CRF_AW-1:0] pc;
  logic [INS_W-1:0]  ins;
  opcode_e           op;
  logic              consumes, fire, idle_wr;
  logic              loop_act;
  logic [JCNT_W-1:0] loop_rem;
  logic [JCNT_W-1:0] jcnt;
  logic [CRF_AW-1:0] jtarget;

  logic [GRP_AW-1:0] idx_a, idx_b;
  logic [GRF_AW-1:0] ra_a, ra_b;
  logic [VW-1:0]     rd_a, rd_b, mul_y, mac_sum;
  logic              grf_we;
  logic [GRF_AW-1:0] grf_waddr;
  logic [VW-1:0]     grf_wdata;

  logic [LANE_W-1:0] srf [SRF_DEPTH];
  logic [LANE_W-1:0] scal;

  assign idle_wr = prog_we && !busy;

  pim_crf #(.DEPTH(CRF_DEPTH), .W(INS_W)) u_crf (
    .clk   (clk),
    .we    (idle_wr && prog_sel == TGT_CRF),
    .waddr (prog_addr),
    .wdata (prog_wdata[INS_W-1:0]),
    .raddr (pc),
    .rdata (ins)
  );

  assign op       = opcode_e'(ins[OPC_HI -: 4]);
  assign consumes = (op != OP_JUMP) && (op != OP_EXIT);
  assign cmd_ready = busy && consumes && !out_valid;
  assign fire     = cmd_valid && cmd_ready;

  // register selection, optionally taken from the column address
  assign idx_a = ins[AAM_BIT] ? cmd_col[GRP_AW-1:0] : ins[AIDX_LO +: GRP_AW];
  assign idx_b = ins[AAM_BIT] ? cmd_col[GRP_AW-1:0] : ins[BIDX_LO +: GRP_AW];
  assign ra_a  = {1'b0, idx_a};
  assign ra_b  = {1'b1, idx_b};

  assign scal  = srf[ins[SIDX_LO +: SRF_AW]];
  assign mul_y = ins[SCAL_BIT] ? {LANES{scal}} : rd_a;

  pim_simd_mac #(.LANES(LANES), .LANE_W(LANE_W)) u_mac (
    .acc   (rd_b),
    .mul_x (cmd_data),
    .mul_y (mul_y),
    .sum   (mac_sum)
  );

  always_comb begin
    grf_we    = 1'b0;
    grf_waddr = ra_b;
    grf_wdata = mac_sum;
    if (idle_wr && prog_sel == TGT_GRF) begin
      grf_we    = 1'b1;
      grf_waddr = prog_addr[GRF_AW-1:0];
      grf_wdata = prog_wdata;
    end else if (fire && op == OP_MOV) begin
      grf_we    = 1'b1;
      grf_waddr = ins[MOVD_LO +: GRF_AW];
      grf_wdata = cmd_data;
    end else if (fire && op == OP_MAC) begin
      grf_we    = 1'b1;
    end
  end

  pim_grf #(.DEPTH(GRF_DEPTH), .W(VW)) u_grf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (grf_we),
    .waddr   (grf_waddr),
    .wdata   (grf_wdata),
    .raddr_a (ra_a),
    .rdata_a (rd_a),
    .raddr_b (ra_b),
    .rdata_b (rd_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SRF_DEPTH; i++) srf[i] <= '0;
    end else if (idle_wr && prog_sel == TGT_SRF) begin
      srf[prog_addr[SRF_AW-1:0]] <= prog_wdata[LANE_W-1:0];
    end
  end

  assign jcnt    = ins[JCNT_W-1:0];
  assign jtarget = pc - CRF_AW'(ins[JDST_LO +: JDST_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pc        <= '0;
      loop_act  <= 1'b0;
      loop_rem  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          done     <= 1'b0;
          pc       <= '0;
          loop_act <= 1'b0;
          loop_rem <= '0;
        end
      end else if (fire) begin
        pc <= pc + 1'b1;
        if (op == OP_FILL && cmd_wr) begin
          out_valid <= 1'b1;
          out_data  <= rd_b;
        end
      end else if (op == OP_JUMP) begin
        if (!loop_act) begin
          if (jcnt == '0) begin
            pc <= pc + 1'b1;
          end else begin
            pc       <= jtarget;
            loop_act <= 1'b1;
            loop_rem <= jcnt - 1'b1;
          end
        end else if (loop_rem == '0) begin
          pc       <= pc + 1'b1;
          loop_act <= 1'b0;
        end else begin
          pc       <= jtarget;
          loop_rem <= loop_rem - 1'b1;
        end
      end else if (op == OP_EXIT) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pim_bank_seq_chk.sv
module pim_bank_seq_chk #(
  parameter int VW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          cmd_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_data
);
  // R1
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_ready);

  // R2
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R11
  done_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R12
  out_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);
endmodule

bind pim_bank_seq pim_bank_seq_chk #(.VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cmd_ready (cmd_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_pim_bank_seq.sv
`timescale 1ns/1ps
module tb_pim_bank_seq;
  localparam int VW = 256;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, cmd_ready, out_valid;
  logic prog_we = 0;
  logic [1:0] prog_sel = 0;
  logic [4:0] prog_addr = 0;
  logic [VW-1:0] prog_wdata = '0;
  logic cmd_valid = 0, cmd_wr = 0;
  logic [2:0] cmd_col = 0;
  logic [VW-1:0] cmd_data = '0, out_data;
  logic out_ready = 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [VW-1:0] exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  pim_bank_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .prog_we(prog_we), .prog_sel(prog_sel), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
    .cmd_data(cmd_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // encoders (fields per R4..R10)
  function automatic logic [31:0] i_mov(input logic [3:0] d); return {4'h1, d, 24'h0}; endfunction
  function automatic logic [31:0] i_mac(input logic [2:0] a, input logic [2:0] b, input logic aam,
                                        input logic sc, input logic [3:0] s);
    return {4'h2, 4'h0, a, b, aam, sc, s, 12'h0};
  endfunction
  function automatic logic [31:0] i_fill(input logic [2:0] b); return {4'h3, 4'h0, 3'h0, b, 18'h0}; endfunction
  function automatic logic [31:0] i_jump(input logic [4:0] d, input logic [11:0] c); return {4'h4, 11'h0, d, c}; endfunction
  localparam logic [31:0] I_EXIT = {4'hF, 28'h0};
  localparam logic [31:0] I_NOP  = 32'h0;

  function automatic logic [VW-1:0] pat(input int seed);
    logic [VW-1:0] v;
    for (int k = 0; k < 16; k++) v[16*k +: 16] = 16'(seed * 37 + k * 1009 + k * k * 3 + 5);
    return v;
  endfunction

  function automatic logic [VW-1:0] lmac(input logic [VW-1:0] acc, input logic [VW-1:0] x, input logic [VW-1:0] y);
    logic [VW-1:0] r;
    for (int k = 0; k < 16; k++) r[16*k +: 16] = 16'(acc[16*k +: 16] + x[16*k +: 16] * y[16*k +: 16]);
    return r;
  endfunction

  task automatic prog(input logic [1:0] sel, input logic [4:0] a, input logic [VW-1:0] d);
    @(negedge clk); prog_we = 1; prog_sel = sel; prog_addr = a; prog_wdata = d;
    @(posedge clk); #1 prog_we = 0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic send_cmd(input logic wr, input logic [2:0] col, input logic [VW-1:0] d);
    @(negedge clk); cmd_valid = 1; cmd_wr = wr; cmd_col = col; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic expect_out(input logic [VW-1:0] v, input string req);
    exp_q.push_back(v); req_q.push_back(req);
  endtask

  task automatic drain;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected output", out_data, '0);
      else begin
        logic [VW-1:0] e;
        string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        check(out_data === e, r, out_data, e);
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [VW-1:0] d [8];
    logic [VW-1:0] x [8];
    logic [VW-1:0] g, y, z, m1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !cmd_ready && !out_valid, "R1 reset state",
          {busy, done, cmd_ready, out_valid}, '0);

    // ---- program 1: loads, address-aligned MAC loop, FILL, NOP, FILL on read
    for (int i = 0; i < 8; i++) prog(2'd0, 5'(i), VW'(i_mov(4'(i))));
    prog(2'd0, 5'd8,  VW'(i_mac(3'd0, 3'd0, 1'b1, 1'b0, 4'd0)));
    prog(2'd0, 5'd9,  VW'(i_jump(5'd1, 12'd7)));
    prog(2'd0, 5'd10, VW'(i_fill(3'd0)));
    prog(2'd0, 5'd11, VW'(i_fill(3'd5)));
    prog(2'd0, 5'd12, VW'(I_NOP));
    prog(2'd0, 5'd13, VW'(i_fill(3'd2)));
    prog(2'd0, 5'd14, VW'(I_EXIT));
    pulse_start();
    @(negedge clk);
    // R2 busy after start
    check(busy && !done, "R2 start raises busy", {busy, done}, 2'b10);
    for (int i = 0; i < 8; i++) begin d[i] = pat(i + 1); send_cmd(1'b0, 3'd0, d[i]); end
    // R7 R10: eight MACs indexed by column, loop repeats 7 more times
    for (int i = 0; i < 8; i++) begin x[i] = pat(40 + i); send_cmd(1'b0, 3'(i), x[i]); end
    // R5 R6 R7 R10: B0 = x0*d0, B5 = x5*d5
    expect_out(lmac('0, x[0], d[0]), "R10 R7 loop MAC B0");
    send_cmd(1'b1, 3'd0, '0);
    expect_out(lmac('0, x[5], d[5]), "R6 R5 MAC B5");
    send_cmd(1'b1, 3'd0, '0);
    drain();
    check(exp_q.size() == 0, "R4 outputs delivered", VW'(exp_q.size()), '0);
    send_cmd(1'b1, 3'd0, pat(99));       // R4 no-op consumes one command
    send_cmd(1'b0, 3'd0, '0);            // R9 FILL on read: no output
    @(negedge clk);
    check(!out_valid, "R9 FILL on read gives no output", VW'(out_valid), '0);
    repeat (3) @(negedge clk);
    check(done && !busy && !cmd_ready, "R11 EXIT sets done", {done, busy, cmd_ready}, 3'b100);

    // ---- program 2: scalar MAC, wrap, writes while busy ignored, back-pressure
    g = '0; y = '0;
    for (int k = 0; k < 16; k++) begin g[16*k +: 16] = 16'h8000 + 16'(k); y[16*k +: 16] = 16'(k + 1); end
    prog(2'd2, 5'd3, VW'(16'hFFFF));
    prog(2'd1, 5'd9, g);
    prog(2'd0, 5'd0, VW'(i_mac(3'd0, 3'd1, 1'b0, 1'b1, 4'd3)));
    prog(2'd0, 5'd1, VW'(i_fill(3'd1)));
    prog(2'd0, 5'd2, VW'(I_EXIT));
    pulse_start();
    @(negedge clk);
    check(!done, "R2 start clears done", VW'(done), '0);
    prog(2'd1, 5'd9, pat(77));           // R3 ignored while busy
    prog(2'd0, 5'd1, VW'(I_EXIT));       // R3 ignored while busy
    send_cmd(1'b0, 3'd0, y);
    m1 = {16{16'hFFFF}};
    #1 out_ready = 0;
    send_cmd(1'b1, 3'd0, '0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R8 R3 and wrap: g - y lane-wise; R12 held under back-pressure
      check(out_valid && !cmd_ready && out_data === lmac(g, y, m1), "R12 R8 R3 held scalar MAC",
            out_data, lmac(g, y, m1));
    end
    expect_out(lmac(g, y, m1), "R12 released");
    @(posedge clk); #1 out_ready = 1;
    drain();
    check(exp_q.size() == 0, "R12 drained", VW'(exp_q.size()), '0);
    repeat (3) @(negedge clk);
    check(done && !busy, "R11 program 2 exit", {done, busy}, 2'b10);
    check(g[15:0] - 16'd1 == 16'h7FFF, "R6 wrap reference", VW'(g[15:0] - 16'd1), VW'(16'h7FFF));

    // ---- program 3: restart at 0, jump with count 0 falls through
    prog(2'd0, 5'd0, VW'(i_mov(4'd8)));
    prog(2'd0, 5'd1, VW'(i_jump(5'd1, 12'd0)));
    prog(2'd0, 5'd2, VW'(i_fill(3'd0)));
    prog(2'd0, 5'd3, VW'(I_EXIT));
    pulse_start();
    z = pat(123);
    send_cmd(1'b0, 3'd6, z);
    expect_out(z, "R10 count 0 falls through, R2 pc 0");
    send_cmd(1'b1, 3'd0, '0);
    drain();
    check(exp_q.size() == 0, "R10 drained", VW'(exp_q.size()), '0);
    repeat (3) @(negedge clk);
    check(done && !busy && !cmd_ready, "R11 program 3 exit", {done, busy, cmd_ready}, 3'b100);
    check(!out_valid, "R1 idle no output", VW'(out_valid), '0);
    finish_run();
  end
endmodule